// File: doc/BRIEF.md
# Memory-Mapped Character Terminal Interface

This block connects one character terminal to a 16-bit processor bus through three consecutive word addresses. The first word is the status word, the second is the receive buffer and the third is the transmit buffer. Software polls or enables interrupts through the status word. It takes received characters from the receive buffer and hands characters for printing to the transmit buffer.

On the device side, a received byte arrives with a one-cycle valid pulse. A character to print leaves as a byte with a one-cycle start pulse, and the device answers with a one-cycle done pulse when printing ends. The block tracks a busy flag, an input-ready flag and an overrun flag. It holds one pending interrupt request for input and one for output, and raises a single interrupt line while either is pending. An acknowledge pulse grants one request at a time.

Top module: `term_mmio`

## Requirements
- R1: With `BASE_ADDR` as the base word address, offset 0 is the status word, offset 1 the receive buffer and offset 2 the transmit buffer. Any other address reads as zero, and writes to it change nothing.
- R2: In `rdData[15:0]` (index 0 least significant), the status word carries interrupt enable at index 0, busy at index 1, input ready at index 2 and overrun at index 4. Every other index reads 0.
- R3: A status write loads interrupt enable from `wrData[0]` and leaves busy, input ready and overrun unchanged.
- R4: A write to the transmit buffer while busy is 0 stores the whole word and sets busy. In the next cycle `txStart` is 1 for exactly one cycle, with `txChar` equal to `wrData[7:0]`.
- R5: A write to the transmit buffer while busy is 1 has no effect. `txStart` stays 0, and `txChar` and the stored word keep their values.
- R6: Busy stays 1 until a `txDone` pulse arrives, which clears it.
- R7: A `rxValid` pulse stores `rxChar` in bits [7:0] of the receive buffer (upper bits read 0) and sets input ready. If input ready was already 1 and the receive buffer is not being read in that cycle, overrun is set and the new byte replaces the old one.
- R8: A read of the receive buffer returns the stored byte, then clears input ready, overrun and the pending input request. If a byte arrives in the same cycle, the arrival wins: input ready is 1 and overrun is 0.
- R9: A write to the receive buffer address has no effect.
- R10: While interrupt enable is 1, a byte arrival sets the pending input request and a completed output sets the pending output request. While it is 0, neither is set. `irq` is 1 while either request is pending.
- R11: Repeated events of one kind before a grant leave a single pending request. An input event and an output event leave two separate requests.
- R12: Each `irqAck` pulse clears one pending request, the input request first when both are pending.
- R13: A synchronous active-high reset clears all flags, buffers, `txStart` and `irq` to zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| addr | input | ADDR_W | Word address of the bus access |
| wrEn | input | 1 | Write strobe |
| rdEn | input | 1 | Read strobe (triggers read side effects) |
| wrData | input | DATA_W | Write data |
| rdData | output | DATA_W | Read data of the addressed word (combinational) |
| rxValid | input | 1 | One-cycle pulse: a received byte is present |
| rxChar | input | CHAR_W | Received byte |
| txStart | output | 1 | One-cycle pulse: start printing `txChar` |
| txChar | output | CHAR_W | Byte to print |
| txDone | input | 1 | One-cycle pulse: printing finished |
| irq | output | 1 | Interrupt request |
| irqAck | input | 1 | One-cycle grant of one pending request |

## Verification
The assertions assume that `rxValid`, `txDone` and `irqAck` are single-cycle pulses, and that `txDone` arrives only while an output operation is in progress. The stimulus drives each device pulse for one cycle only and issues a done pulse only after a transmit write has been accepted. It never holds a bus strobe for more than one cycle, so every read side effect happens exactly once. The same-cycle collisions the requirements name, such as a read meeting an arrival or a write meeting a busy device, are placed on purpose.

// File: rtl/term_mmio_pkg.sv
package term_mmio_pkg;

  // Word offsets from the base address; the order is software visible.
  localparam int NUM_WORDS = 3;
  localparam int OFF_STAT  = 0;
  localparam int OFF_RXB   = 1;
  localparam int OFF_TXB   = 2;

  // Status field positions (index 0 = least significant).
  localparam int BIT_IE    = 0;
  localparam int BIT_BUSY  = 1;
  localparam int BIT_RDY   = 2;
  localparam int BIT_OVR   = 4;

  typedef enum logic [1:0] {
    SEL_NONE = 2'd0,
    SEL_STAT = 2'd1,
    SEL_RXB  = 2'd2,
    SEL_TXB  = 2'd3
  } rdSel_e;

  // Strobes from control to datapath.
  typedef struct packed {
    logic   loadRx;
    logic   loadTx;
    rdSel_e rdSel;
  } dpCtl_t;

endpackage

// File: rtl/term_mmio_decode.sv
module term_mmio_decode
  import term_mmio_pkg::*;
#(
  parameter int          ADDR_W    = 8,
  parameter int unsigned BASE_ADDR = 'hF0
) (
  input  logic [ADDR_W-1:0]    addr,
  output logic [NUM_WORDS-1:0] hit
);

  for (genvar k = 0; k < NUM_WORDS; k++) begin : g_hit
    localparam logic [ADDR_W-1:0] WORD_ADDR = ADDR_W'(BASE_ADDR + k);
    assign hit[k] = (addr == WORD_ADDR);
  end

endmodule

// File: rtl/term_mmio_ctrl.sv
module term_mmio_ctrl
  import term_mmio_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [NUM_WORDS-1:0] hit,
  input  logic                 wrEn,
  input  logic                 rdEn,
  input  logic                 ieIn,
  input  logic                 rxValid,
  input  logic                 txDone,
  input  logic                 irqAck,
  output dpCtl_t               ctl,
  output logic [DATA_W-1:0]    statusWord,
  output logic                 busy,
  output logic                 ready,
  output logic                 overrun,
  output logic                 pendIn,
  output logic                 pendOut,
  output logic                 txStart,
  output logic                 irq
);

  logic ieQ;
  logic wrStat, rdRx, wrTxOk, doneEvt, ackIn, ackOut;
  logic ieNext, busyNext, readyNext, ovrNext, pendInNext, pendOutNext;

  // Bus events
  assign wrStat  = wrEn & hit[OFF_STAT];
  assign rdRx    = rdEn & hit[OFF_RXB];
  assign wrTxOk  = wrEn & hit[OFF_TXB] & ~busy;
  assign doneEvt = txDone & busy;

  // One grant per acknowledge, input first
  assign ackIn   = irqAck & pendIn;
  assign ackOut  = irqAck & ~pendIn & pendOut;

  always_comb begin
    ieNext = ieQ;
    if (wrStat) ieNext = ieIn;

    busyNext = busy;
    if (wrTxOk)       busyNext = 1'b1;
    else if (doneEvt) busyNext = 1'b0;

    readyNext = ready;
    ovrNext   = overrun;
    if (rxValid) begin
      readyNext = 1'b1;
      ovrNext   = overrun | (ready & ~rdRx);
      if (rdRx) ovrNext = 1'b0;
    end else if (rdRx) begin
      readyNext = 1'b0;
      ovrNext   = 1'b0;
    end

    pendInNext = pendIn;
    if (ackIn | rdRx)      pendInNext = 1'b0;
    if (rxValid & ieQ)     pendInNext = 1'b1;

    pendOutNext = pendOut;
    if (ackOut)            pendOutNext = 1'b0;
    if (doneEvt & ieQ)     pendOutNext = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ieQ     <= 1'b0;
      busy    <= 1'b0;
      ready   <= 1'b0;
      overrun <= 1'b0;
      pendIn  <= 1'b0;
      pendOut <= 1'b0;
      txStart <= 1'b0;
    end else begin
      ieQ     <= ieNext;
      busy    <= busyNext;
      ready   <= readyNext;
      overrun <= ovrNext;
      pendIn  <= pendInNext;
      pendOut <= pendOutNext;
      txStart <= wrTxOk;
    end
  end

  assign irq = pendIn | pendOut;

  // Strobes to datapath
  always_comb begin
    ctl.loadRx = rxValid;
    ctl.loadTx = wrTxOk;
    if (hit[OFF_STAT])     ctl.rdSel = SEL_STAT;
    else if (hit[OFF_RXB]) ctl.rdSel = SEL_RXB;
    else if (hit[OFF_TXB]) ctl.rdSel = SEL_TXB;
    else                   ctl.rdSel = SEL_NONE;
  end

  always_comb begin
    statusWord           = '0;
    statusWord[BIT_IE]   = ieQ;
    statusWord[BIT_BUSY] = busy;
    statusWord[BIT_RDY]  = ready;
    statusWord[BIT_OVR]  = overrun;
  end

endmodule

// File: rtl/term_mmio_dp.sv
module term_mmio_dp
  import term_mmio_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int CHAR_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  dpCtl_t            ctl,
  input  logic [DATA_W-1:0] wrData,
  input  logic [CHAR_W-1:0] rxChar,
  input  logic [DATA_W-1:0] statusWord,
  output logic [DATA_W-1:0] rdData,
  output logic [CHAR_W-1:0] txChar
);

  logic [CHAR_W-1:0] rxBuf;
  logic [DATA_W-1:0] txBuf;

  always_ff @(posedge clk) begin
    if (rst) begin
      rxBuf <= '0;
      txBuf <= '0;
    end else begin
      if (ctl.loadRx) rxBuf <= rxChar;
      if (ctl.loadTx) txBuf <= wrData;
    end
  end

  assign txChar = txBuf[CHAR_W-1:0];

  always_comb begin
    unique case (ctl.rdSel)
      SEL_STAT: rdData = statusWord;
      SEL_RXB:  rdData = DATA_W'(rxBuf);
      SEL_TXB:  rdData = txBuf;
      default:  rdData = '0;
    endcase
  end

endmodule

// File: rtl/term_mmio.sv
module term_mmio
  import term_mmio_pkg::*;
#(
  parameter int          ADDR_W    = 8,
  parameter int          DATA_W    = 16,
  parameter int          CHAR_W    = 8,
  parameter int unsigned BASE_ADDR = 'hF0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] addr,
  input  logic              wrEn,
  input  logic              rdEn,
  input  logic [DATA_W-1:0] wrData,
  output logic [DATA_W-1:0] rdData,
  input  logic              rxValid,
  input  logic [CHAR_W-1:0] rxChar,
  output logic              txStart,
  output logic [CHAR_W-1:0] txChar,
  input  logic              txDone,
  output logic              irq,
  input  logic              irqAck
);

  logic [NUM_WORDS-1:0] hit;
  dpCtl_t               ctl;
  logic [DATA_W-1:0]    statusWord;
  logic                 busy, ready, overrun, pendIn, pendOut;

  term_mmio_decode #(.ADDR_W(ADDR_W), .BASE_ADDR(BASE_ADDR)) u_decode (
    .addr (addr),
    .hit  (hit)
  );

  term_mmio_ctrl #(.DATA_W(DATA_W)) u_ctrl (
    .clk        (clk),
    .rst        (rst),
    .hit        (hit),
    .wrEn       (wrEn),
    .rdEn       (rdEn),
    .ieIn       (wrData[BIT_IE]),
    .rxValid    (rxValid),
    .txDone     (txDone),
    .irqAck     (irqAck),
    .ctl        (ctl),
    .statusWord (statusWord),
    .busy       (busy),
    .ready      (ready),
    .overrun    (overrun),
    .pendIn     (pendIn),
    .pendOut    (pendOut),
    .txStart    (txStart),
    .irq        (irq)
  );

  term_mmio_dp #(.DATA_W(DATA_W), .CHAR_W(CHAR_W)) u_dp (
    .clk        (clk),
    .rst        (rst),
    .ctl        (ctl),
    .wrData     (wrData),
    .rxChar     (rxChar),
    .statusWord (statusWord),
    .rdData     (rdData),
    .txChar     (txChar)
  );

endmodule

// File: rtl/term_mmio_chk.sv
module term_mmio_chk #(
  parameter int          ADDR_W    = 8,
  parameter int unsigned BASE_ADDR = 'hF0
) (
  input logic              clk,
  input logic              rst,
  input logic [ADDR_W-1:0] addr,
  input logic              wrEn,
  input logic              rdEn,
  input logic              rxValid,
  input logic              txDone,
  input logic              txStart,
  input logic              irqAck,
  input logic              busy,
  input logic              ready,
  input logic              overrun,
  input logic              pendIn,
  input logic              pendOut
);

  localparam logic [ADDR_W-1:0] A_RX = ADDR_W'(BASE_ADDR + 1);
  localparam logic [ADDR_W-1:0] A_TX = ADDR_W'(BASE_ADDR + 2);

  AST_TX_START_ON_IDLE_WRITE: assert property (@(posedge clk) disable iff (rst)
    (wrEn && addr == A_TX && !busy) |=> (txStart && busy)); // R4
  AST_TX_START_SINGLE: assert property (@(posedge clk) disable iff (rst)
    txStart |=> !txStart); // R4
  AST_BUSY_WRITE_NO_START: assert property (@(posedge clk) disable iff (rst)
    (wrEn && addr == A_TX && busy) |=> !txStart); // R5
  AST_BUSY_HOLD: assert property (@(posedge clk) disable iff (rst)
    (busy && !txDone) |=> busy); // R6
  AST_DONE_CLEARS_BUSY: assert property (@(posedge clk) disable iff (rst)
    (busy && txDone) |=> !busy); // R6
  AST_OVERRUN_NEEDS_READY: assert property (@(posedge clk) disable iff (rst)
    overrun |-> ready); // R7
  AST_READ_CLEARS_INPUT: assert property (@(posedge clk) disable iff (rst)
    (rdEn && addr == A_RX && !rxValid) |=> (!ready && !overrun && !pendIn)); // R8
  AST_NO_EVENT_NO_PEND: assert property (@(posedge clk) disable iff (rst)
    (!rxValid && !pendIn) |=> !pendIn); // R10
  AST_ACK_INPUT_FIRST: assert property (@(posedge clk) disable iff (rst)
    (pendIn && pendOut && irqAck && !rxValid) |=> (!pendIn && pendOut)); // R12

endmodule

bind term_mmio term_mmio_chk #(.ADDR_W(ADDR_W), .BASE_ADDR(BASE_ADDR)) u_chk (
  .clk     (clk),
  .rst     (rst),
  .addr    (addr),
  .wrEn    (wrEn),
  .rdEn    (rdEn),
  .rxValid (rxValid),
  .txDone  (txDone),
  .txStart (txStart),
  .irqAck  (irqAck),
  .busy    (busy),
  .ready   (ready),
  .overrun (overrun),
  .pendIn  (pendIn),
  .pendOut (pendOut)
);

// File: tb/term_mmio_tb.sv
module term_mmio_tb;

  localparam int ADDR_W = 8;
  localparam int DATA_W = 16;
  localparam int CHAR_W = 8;
  localparam logic [7:0] A_ST   = 8'hF0;
  localparam logic [7:0] A_RX   = 8'hF1;
  localparam logic [7:0] A_TX   = 8'hF2;
  localparam logic [7:0] A_NONE = 8'hF3;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic [ADDR_W-1:0] addr = A_NONE;
  logic              wrEn = 1'b0, rdEn = 1'b0;
  logic [DATA_W-1:0] wrData = '0;
  logic [DATA_W-1:0] rdData;
  logic              rxValid = 1'b0;
  logic [CHAR_W-1:0] rxChar = '0;
  logic              txStart;
  logic [CHAR_W-1:0] txChar;
  logic              txDone = 1'b0;
  logic              irq;
  logic              irqAck = 1'b0;

  int checks = 0;
  int fails  = 0;
  bit finished = 0;
  logic [DATA_W-1:0] expQ[$];
  string             tagQ[$];

  always #5 clk = ~clk;

  term_mmio #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .CHAR_W(CHAR_W), .BASE_ADDR('hF0)) u_dut (
    .clk(clk), .rst(rst), .addr(addr), .wrEn(wrEn), .rdEn(rdEn), .wrData(wrData),
    .rdData(rdData), .rxValid(rxValid), .rxChar(rxChar), .txStart(txStart),
    .txChar(txChar), .txDone(txDone), .irq(irq), .irqAck(irqAck)
  );

  task automatic check(input string tag, input logic [DATA_W-1:0] act, input logic [DATA_W-1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic drive(input logic wr, input logic rd, input logic [7:0] a, input logic [15:0] wd,
                       input logic rxv, input logic [7:0] rc, input logic dn, input logic ak);
    @(negedge clk);
    wrEn = wr; rdEn = rd; addr = a; wrData = wd;
    rxValid = rxv; rxChar = rc; txDone = dn; irqAck = ak;
  endtask

  task automatic nop();                      drive(0, 0, A_NONE, 16'h0, 0, 8'h0, 0, 0); endtask
  task automatic busWr(input logic [7:0] a, input logic [15:0] d); drive(1, 0, a, d, 0, 8'h0, 0, 0); endtask
  task automatic rxByte(input logic [7:0] c); drive(0, 0, A_NONE, 16'h0, 1, c, 0, 0); endtask
  task automatic devDone();                  drive(0, 0, A_NONE, 16'h0, 0, 8'h0, 1, 0); endtask
  task automatic ackPulse();                 drive(0, 0, A_NONE, 16'h0, 0, 8'h0, 0, 1); endtask

  // Driver side of the scoreboard: queue the expected word, then issue the read.
  task automatic busRd(input logic [7:0] a, input logic [15:0] exp, input string tag);
    expQ.push_back(exp);
    tagQ.push_back(tag);
    drive(0, 1, a, 16'h0, 0, 8'h0, 0, 0);
  endtask

  // Monitor side: compare each read beat against the queue head.
  initial begin
    forever begin
      @(negedge clk);
      #3;
      if (rdEn) begin
        if (expQ.size() == 0) begin
          check("R1 unexpected read", rdData, 16'hxxxx);
        end else begin
          check(tagQ.pop_front(), rdData, expQ.pop_front());
        end
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      fails++;
      $display("FAIL watchdog R13 actual=hung expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;

    // Reset state
    busRd(A_ST, 16'h0000, "R13 status after reset");
    #3; check("R13 irq after reset", 16'(irq), 16'h0);
    check("R13 txStart after reset", 16'(txStart), 16'h0);
    busRd(A_RX, 16'h0000, "R13 rx buffer after reset");

    // Status write touches only interrupt enable
    busWr(A_ST, 16'hFFFF);
    busRd(A_ST, 16'h0001, "R3 only enable written");

    // Transmit accepted when idle
    busWr(A_TX, 16'h1241);
    nop(); #3;
    check("R4 txStart pulse", 16'(txStart), 16'h1);
    check("R4 txChar", 16'(txChar), 16'h0041);
    busRd(A_ST, 16'h0003, "R2,R6 busy with enable");
    #3; check("R4 txStart one cycle", 16'(txStart), 16'h0);

    // Transmit refused while busy
    busWr(A_TX, 16'h0042);
    nop(); #3;
    check("R5 no start while busy", 16'(txStart), 16'h0);
    check("R5 txChar kept", 16'(txChar), 16'h0041);
    busRd(A_TX, 16'h1241, "R5 stored word kept");

    // Status write while busy keeps busy
    busWr(A_ST, 16'h0000);
    busRd(A_ST, 16'h0002, "R3 busy survives status write");
    busWr(A_ST, 16'h0001);

    // Completion
    devDone();
    busRd(A_ST, 16'h0001, "R6 done clears busy");
    #3; check("R10 output request raises irq", 16'(irq), 16'h1);
    ackPulse();
    nop(); #3; check("R12 ack clears request", 16'(irq), 16'h0);

    // Receive, overrun, read side effects
    rxByte(8'h5A);
    busRd(A_ST, 16'h0005, "R7 input ready");
    #3; check("R10 input request raises irq", 16'(irq), 16'h1);
    rxByte(8'hA5);
    busRd(A_ST, 16'h0015, "R2,R7 overrun set");
    busRd(A_RX, 16'h00A5, "R7 newest byte kept");
    busRd(A_ST, 16'h0001, "R8 read clears ready and overrun");
    #3; check("R8 read cancels input request", 16'(irq), 16'h0);

    // Write to receive buffer ignored
    busWr(A_RX, 16'h00FF);
    busRd(A_ST, 16'h0001, "R9 status unchanged");
    busRd(A_RX, 16'h00A5, "R9 buffer unchanged");

    // Same-kind coalescing
    rxByte(8'h11);
    rxByte(8'h22);
    ackPulse();
    nop(); #3; check("R11 one input request for two arrivals", 16'(irq), 16'h0);
    busRd(A_RX, 16'h0022, "R11 last byte");

    // Two kinds, input granted first
    rxByte(8'h33);
    busWr(A_TX, 16'h0044);
    devDone();
    nop(); #3; check("R10 both pending", 16'(irq), 16'h1);
    ackPulse();
    busRd(A_RX, 16'h0033, "R12 byte read");
    #3; check("R11 second request remains", 16'(irq), 16'h1);
    nop(); #3; check("R12 input granted first", 16'(irq), 16'h1);
    ackPulse();
    nop(); #3; check("R12 second ack clears output", 16'(irq), 16'h0);

    // Interrupts disabled
    busWr(A_ST, 16'h0000);
    rxByte(8'h77);
    busWr(A_TX, 16'h0055);
    devDone();
    nop(); #3; check("R10 no request when disabled", 16'(irq), 16'h0);
    busRd(A_ST, 16'h0004, "R10 ready without enable");

    // Read colliding with arrival
    expQ.push_back(16'h0077);
    tagQ.push_back("R8 collision returns old byte");
    drive(0, 1, A_RX, 16'h0, 1, 8'h02, 0, 0);
    busRd(A_ST, 16'h0004, "R8 arrival wins over read");
    busRd(A_RX, 16'h0002, "R8 new byte stored");

    // Unmapped address
    busRd(A_NONE, 16'h0000, "R1 unmapped reads zero");
    busWr(A_NONE, 16'hFFFF);
    busRd(A_ST, 16'h0000, "R1 unmapped write ignored");
    busRd(A_TX, 16'h0055, "R1 transmit word intact");

    nop();
    nop();
    #3;
    if (expQ.size() != 0) check("R1 reads left unchecked", 16'(expQ.size()), 16'h0);
    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule